// File: doc/BRIEF.md
# Shared interrupt source controller

This block gathers a configurable number of external interrupt lines that several processor cores share, and turns them into one request line per core. Each line passes through a two-flop synchroniser and then a conditioning stage set per source: level or edge sensing, the active level or edge direction, and a both-edges option. Edge-sensed sources keep a latch that holds the event until software acknowledges it. The same latch can also be raised by software, which lets one core interrupt another.

Every source carries an enable bit, a routing record that names a CPU input pin and carries an enable flag, and a bitmask of target cores. A core's request is raised while any source that is pending, enabled, pin-routed and aimed at that core exists. A per-core pin vector shows which pin that request lands on. Software programs the block through single-word writes: the source index sits in the low byte, with the payload above it. Pending and enable state read back as 32-bit words.

Top module: `shared_irq_ctrl`

## Requirements
- R1: The source count is 8 × (CFG_CNT + 1). Reading address 0x00 returns CFG_CNT in bits [7:0]. Source index NUM_SRC-1 is fully usable.
- R2: After reset, every source is level-sensed and active-high, with its enable clear, no pin routing and no core routing. All requests are low and pending, enable and request read as zero.
- R3: A level source (mode bit 1 = 0) is pending while its synchronised input equals the active level: high when mode bit 0 = 0, low when it is 1. Pending follows the pin two clocks after a change.
- R4: An edge source (mode bit 1 = 1, bit 2 = 0) latches on a rising input when bit 0 = 0 and on a falling input when bit 0 = 1. The latch holds after the input returns. Mode writes go to address 0x01 with the mode in data[10:8].
- R5: With mode bit 2 set in edge mode, both input edges latch the source, whatever the value of bit 0.
- R6: A write to 0x04 with data[31] = 0 clears the indexed edge latch. If a hardware edge is detected in the same cycle, the latch stays set.
- R7: A write to 0x04 with data[31] = 1 sets the indexed edge latch, so the source becomes pending.
- R8: A write to 0x02 enables the indexed source, and a write to 0x03 disables it. Disabling drops the source's request but leaves its pending bit unchanged.
- R9: irqReq[c] is high while some source is pending, enabled, has its pin flag set and has core bit c set. Core routing is written at 0x06 with the mask in data[8+:NUM_CORES]. Pin routing is written at 0x05 with the flag in data[31] and the pin in data[15:8].
- R10: irqPin[c*NUM_PINS+p] is high while a source that drives irqReq[c] has pin number p. A pin number of NUM_PINS or more raises no pin bit, but it still raises irqReq.
- R11: Read address 0x08+w returns pending bits [32w+31:32w], and 0x10+w returns the enable bits for the same range. Words past the source count, and any other address, read as zero.
- R12: A write whose index is NUM_SRC or more changes nothing. A core-routing write with a bit set at position NUM_CORES or above is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcIn | input | NUM_SRC | Raw interrupt lines |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 5 | Write address |
| wrData | input | 32 | Write data: index in [7:0], payload above |
| rdAddr | input | 5 | Read address |
| rdData | output | 32 | Read data, combinational from rdAddr |
| irqReq | output | NUM_CORES | One request per core |
| irqPin | output | NUM_CORES*NUM_PINS | Per-core pin that the request lands on |

## Verification
The bench builds the block with CFG_CNT = 1, NUM_CORES = 4 and NUM_PINS = 6. That gives 16 sources in a single read word, so word 1 must read zero, and index 15 is the top usable source. With those values, index 16 and 200, core bit 5 and pin 7 are all out of range, so each of the rejection and no-pin-output rules can be exercised. The directed sequence lines up a software acknowledge with a detected edge in the same clock, so the rule that the hardware edge wins is tested directly.

// File: rtl/shirq_pkg.sv
package shirq_pkg;
  localparam int IDX_W = 8;
  localparam int ARG_W = 23;

  localparam logic [4:0] ADR_CFG_INFO   = 5'h00;
  localparam logic [4:0] ADR_SRC_MODE   = 5'h01;
  localparam logic [4:0] ADR_MASK_ON    = 5'h02;
  localparam logic [4:0] ADR_MASK_OFF   = 5'h03;
  localparam logic [4:0] ADR_EDGE_CMD   = 5'h04;
  localparam logic [4:0] ADR_PIN_ROUTE  = 5'h05;
  localparam logic [4:0] ADR_CORE_ROUTE = 5'h06;

  typedef struct packed {
    logic             cfgWe;
    logic             maskSet;
    logic             maskClr;
    logic             edgeSet;
    logic             edgeClr;
    logic             pinWe;
    logic             coreWe;
    logic             hiBit;
    logic [IDX_W-1:0] idx;
    logic [ARG_W-1:0] arg;
  } wrStrobe_t;

  typedef struct packed {
    logic       cfgRd;
    logic       pendRd;
    logic       maskRd;
    logic [2:0] word;
  } rdSel_t;
endpackage

// File: rtl/shirq_ctrl.sv
module shirq_ctrl
  import shirq_pkg::*;
#(
  parameter int NUM_SRC = 16
) (
  input  logic        wrEn,
  input  logic [4:0]  wrAddr,
  input  logic [31:0] wrData,
  input  logic [4:0]  rdAddr,
  output wrStrobe_t   strb,
  output rdSel_t      rdSel
);
  logic idxOk;
  logic wrGo;

  assign idxOk = {1'b0, wrData[7:0]} < 9'(NUM_SRC);
  assign wrGo  = wrEn && idxOk;

  always_comb begin
    strb.cfgWe   = wrGo && (wrAddr == ADR_SRC_MODE);
    strb.maskSet = wrGo && (wrAddr == ADR_MASK_ON);
    strb.maskClr = wrGo && (wrAddr == ADR_MASK_OFF);
    strb.edgeSet = wrGo && (wrAddr == ADR_EDGE_CMD) && wrData[31];
    strb.edgeClr = wrGo && (wrAddr == ADR_EDGE_CMD) && !wrData[31];
    strb.pinWe   = wrGo && (wrAddr == ADR_PIN_ROUTE);
    strb.coreWe  = wrGo && (wrAddr == ADR_CORE_ROUTE);
    strb.hiBit   = wrData[31];
    strb.idx     = wrData[7:0];
    strb.arg     = wrData[30:8];
  end

  always_comb begin
    rdSel.cfgRd  = (rdAddr == ADR_CFG_INFO);
    rdSel.pendRd = (rdAddr[4:3] == 2'b01);
    rdSel.maskRd = (rdAddr[4:3] == 2'b10);
    rdSel.word   = rdAddr[2:0];
  end
endmodule

// File: rtl/shirq_datapath.sv
module shirq_datapath
  import shirq_pkg::*;
#(
  parameter int CFG_CNT   = 1,
  parameter int NUM_SRC   = 16,
  parameter int NUM_CORES = 4,
  parameter int NUM_PINS  = 6
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_SRC-1:0]            srcIn,
  input  wrStrobe_t                     strb,
  input  rdSel_t                        rdSel,
  output logic [31:0]                   rdData,
  output logic [NUM_CORES-1:0]          irqReq,
  output logic [NUM_CORES*NUM_PINS-1:0] irqPin
);
  localparam int NUM_WORDS = (NUM_SRC + 31) / 32;
  localparam int PAD_W     = NUM_WORDS * 32;

  logic [NUM_SRC-1:0]   syncA, syncB, syncC;
  logic [NUM_SRC-1:0]   polQ, trigQ, dualQ, maskQ, pinEnQ, latchQ;
  logic [7:0]           pinNumQ  [NUM_SRC];
  logic [NUM_CORES-1:0] coreMapQ [NUM_SRC];
  logic [NUM_SRC-1:0]   edgeHw, pend;
  logic                 coreOk;
  logic [PAD_W-1:0]     pendPad, maskPad;

  assign coreOk = (strb.arg >> NUM_CORES) == '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      syncC <= '0;
    end else begin
      syncA <= srcIn;
      syncB <= syncA;
      syncC <= syncB;
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_SRC; i++) begin
      if (!trigQ[i])     edgeHw[i] = 1'b0;
      else if (dualQ[i]) edgeHw[i] = syncB[i] ^ syncC[i];
      else if (polQ[i])  edgeHw[i] = !syncB[i] && syncC[i];
      else               edgeHw[i] = syncB[i] && !syncC[i];
      pend[i] = trigQ[i] ? latchQ[i] : (syncB[i] ^ polQ[i]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      polQ   <= '0;
      trigQ  <= '0;
      dualQ  <= '0;
      maskQ  <= '0;
      pinEnQ <= '0;
      latchQ <= '0;
      for (int i = 0; i < NUM_SRC; i++) begin
        pinNumQ[i]  <= '0;
        coreMapQ[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_SRC; i++) begin
        if (strb.idx == 8'(i)) begin
          if (strb.cfgWe) begin
            polQ[i]  <= strb.arg[0];
            trigQ[i] <= strb.arg[1];
            dualQ[i] <= strb.arg[2];
          end
          if (strb.maskSet)      maskQ[i] <= 1'b1;
          else if (strb.maskClr) maskQ[i] <= 1'b0;
          if (strb.pinWe) begin
            pinEnQ[i]  <= strb.hiBit;
            pinNumQ[i] <= strb.arg[7:0];
          end
          if (strb.coreWe && coreOk) coreMapQ[i] <= strb.arg[NUM_CORES-1:0];
        end
        if (edgeHw[i] || (strb.edgeSet && strb.idx == 8'(i)))
          latchQ[i] <= 1'b1;
        else if (strb.edgeClr && strb.idx == 8'(i))
          latchQ[i] <= 1'b0;
      end
    end
  end

  always_comb begin
    irqReq = '0;
    irqPin = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      for (int c = 0; c < NUM_CORES; c++) begin
        if (pend[i] && maskQ[i] && pinEnQ[i] && coreMapQ[i][c]) begin
          irqReq[c] = 1'b1;
          for (int p = 0; p < NUM_PINS; p++)
            if (pinNumQ[i] == 8'(p)) irqPin[c*NUM_PINS+p] = 1'b1;
        end
      end
    end
  end

  assign pendPad = PAD_W'(pend);
  assign maskPad = PAD_W'(maskQ);

  always_comb begin
    rdData = '0;
    if (rdSel.cfgRd)
      rdData = 32'(CFG_CNT);
    else if (rdSel.pendRd && int'(rdSel.word) < NUM_WORDS)
      rdData = pendPad[int'(rdSel.word)*32 +: 32];
    else if (rdSel.maskRd && int'(rdSel.word) < NUM_WORDS)
      rdData = maskPad[int'(rdSel.word)*32 +: 32];
  end

  for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_chk
    AST_MASK_ON: assert property (@(posedge clk) disable iff (!rstN)
      (strb.maskSet && strb.idx == 8'(gi)) |=> maskQ[gi]); // R8
    AST_MASK_OFF: assert property (@(posedge clk) disable iff (!rstN)
      (strb.maskClr && strb.idx == 8'(gi)) |=> !maskQ[gi]); // R8
    AST_EDGE_RAISE: assert property (@(posedge clk) disable iff (!rstN)
      (strb.edgeSet && strb.idx == 8'(gi)) |=> latchQ[gi]); // R7
    AST_EDGE_ACK: assert property (@(posedge clk) disable iff (!rstN)
      (strb.edgeClr && strb.idx == 8'(gi) && !edgeHw[gi]) |=> !latchQ[gi]); // R6
  end

  for (genvar gc = 0; gc < NUM_CORES; gc++) begin : g_core
    AST_PIN_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
      (|irqPin[gc*NUM_PINS +: NUM_PINS]) |-> irqReq[gc]); // R10
  end

  AST_REQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (|irqReq) |-> (|(pend & maskQ & pinEnQ))); // R9
endmodule

// File: rtl/shared_irq_ctrl.sv
module shared_irq_ctrl
  import shirq_pkg::*;
#(
  parameter int CFG_CNT   = 1,
  parameter int NUM_CORES = 4,
  parameter int NUM_PINS  = 6,
  localparam int NUM_SRC  = 8 * (CFG_CNT + 1)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_SRC-1:0]            srcIn,
  input  logic                          wrEn,
  input  logic [4:0]                    wrAddr,
  input  logic [31:0]                   wrData,
  input  logic [4:0]                    rdAddr,
  output logic [31:0]                   rdData,
  output logic [NUM_CORES-1:0]          irqReq,
  output logic [NUM_CORES*NUM_PINS-1:0] irqPin
);
  wrStrobe_t strb;
  rdSel_t    rdSel;

  shirq_ctrl #(.NUM_SRC(NUM_SRC)) uCtrl (
    .wrEn  (wrEn),
    .wrAddr(wrAddr),
    .wrData(wrData),
    .rdAddr(rdAddr),
    .strb  (strb),
    .rdSel (rdSel)
  );

  shirq_datapath #(
    .CFG_CNT  (CFG_CNT),
    .NUM_SRC  (NUM_SRC),
    .NUM_CORES(NUM_CORES),
    .NUM_PINS (NUM_PINS)
  ) uData (
    .clk   (clk),
    .rstN  (rstN),
    .srcIn (srcIn),
    .strb  (strb),
    .rdSel (rdSel),
    .rdData(rdData),
    .irqReq(irqReq),
    .irqPin(irqPin)
  );
endmodule

// File: tb/shared_irq_ctrl_test.sv
module shared_irq_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 16;
  localparam int NC = 4;
  localparam int NP = 6;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [NS-1:0]   srcIn = '0;
  logic            wrEn = 1'b0;
  logic [4:0]      wrAddr = '0;
  logic [31:0]     wrData = '0;
  logic [4:0]      rdAddr = '0;
  logic [31:0]     rdData;
  logic [NC-1:0]   irqReq;
  logic [NC*NP-1:0] irqPin;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  shared_irq_ctrl #(.CFG_CNT(1), .NUM_CORES(NC), .NUM_PINS(NP)) uut (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .irqReq(irqReq),
    .irqPin(irqPin)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference state
  bit m_s1[NS], m_s2[NS], m_s3[NS], m_hw[NS];
  bit m_pol[NS], m_trig[NS], m_dual[NS], m_mask[NS], m_pinEn[NS], m_latch[NS];
  int m_pin[NS];
  bit [NC-1:0] m_core[NS];

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NS; i++) begin
        m_s1[i] = 0; m_s2[i] = 0; m_s3[i] = 0; m_pol[i] = 0; m_trig[i] = 0;
        m_dual[i] = 0; m_mask[i] = 0; m_pinEn[i] = 0; m_latch[i] = 0;
        m_pin[i] = 0; m_core[i] = '0;
      end
    end else begin
      for (int i = 0; i < NS; i++) begin
        if (!m_trig[i]) m_hw[i] = 0;
        else if (m_dual[i]) m_hw[i] = m_s2[i] != m_s3[i];
        else if (m_pol[i]) m_hw[i] = !m_s2[i] && m_s3[i];
        else m_hw[i] = m_s2[i] && !m_s3[i];
      end
      if (wrEn && int'(wrData[7:0]) < NS) begin
        int k;
        k = int'(wrData[7:0]);
        case (wrAddr)
          5'h01: begin m_pol[k] = wrData[8]; m_trig[k] = wrData[9]; m_dual[k] = wrData[10]; end
          5'h02: m_mask[k] = 1;
          5'h03: m_mask[k] = 0;
          5'h04: m_latch[k] = wrData[31];
          5'h05: begin m_pinEn[k] = wrData[31]; m_pin[k] = int'(wrData[15:8]); end
          5'h06: if ((wrData[30:8] >> NC) == 0) m_core[k] = wrData[8+:NC];
          default: ;
        endcase
      end
      for (int i = 0; i < NS; i++) begin
        if (m_hw[i]) m_latch[i] = 1;
        m_s3[i] = m_s2[i]; m_s2[i] = m_s1[i]; m_s1[i] = srcIn[i];
      end
    end
  end

  function automatic bit exp_pend(int i);
    return m_trig[i] ? m_latch[i] : (m_s2[i] ^ m_pol[i]);
  endfunction

  function automatic logic [NC-1:0] exp_req();
    logic [NC-1:0] r = '0;
    for (int i = 0; i < NS; i++)
      if (exp_pend(i) && m_mask[i] && m_pinEn[i]) r |= m_core[i];
    return r;
  endfunction

  function automatic logic [NC*NP-1:0] exp_pin();
    logic [NC*NP-1:0] r = '0;
    for (int i = 0; i < NS; i++)
      for (int c = 0; c < NC; c++)
        if (exp_pend(i) && m_mask[i] && m_pinEn[i] && m_core[i][c] && m_pin[i] < NP)
          r[c*NP + m_pin[i]] = 1'b1;
    return r;
  endfunction

  function automatic logic [31:0] exp_rd(logic [4:0] a);
    logic [31:0] r = '0;
    if (a == 5'h00) r = 32'd1;
    else if (a == 5'h08) for (int i = 0; i < NS; i++) r[i] = exp_pend(i);
    else if (a == 5'h10) for (int i = 0; i < NS; i++) r[i] = m_mask[i];
    return r;
  endfunction

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rstN && !done) begin
      checks += 3;
      if (irqReq !== exp_req()) begin
        errors++;
        $display("FAIL R9 irqReq act=%b exp=%b t=%0t", irqReq, exp_req(), $time);
      end
      if (irqPin !== exp_pin()) begin
        errors++;
        $display("FAIL R10 irqPin act=%h exp=%h t=%0t", irqPin, exp_pin(), $time);
      end
      if (rdData !== exp_rd(rdAddr)) begin
        errors++;
        $display("FAIL R11 rdData@%h act=%h exp=%h t=%0t", rdAddr, rdData, exp_rd(rdAddr), $time);
      end
    end
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    tick();
    wrEn = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic rdchk(input string tag, input logic [4:0] a, input logic [31:0] exp);
    rdAddr = a;
    #1;
    chk(tag, rdData, exp);
  endtask

  task automatic wait3();
    repeat (3) tick();
  endtask

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    chk("R2 reset request", 32'(irqReq), 32'h0);
    rdchk("R1 config field", 5'h00, 32'd1);
    rdchk("R2 reset pending", 5'h08, 32'h0);
    rdchk("R2 reset enables", 5'h10, 32'h0);

    // source 3: level, pin 2, core 1
    wr(5'h05, {1'b1, 23'd2, 8'd3});
    wr(5'h06, {1'b0, 23'b0010, 8'd3});
    wr(5'h02, 32'd3);
    srcIn[3] = 1'b1; wait3();
    rdchk("R3 level high pending", 5'h08, 32'h08);
    chk("R9 core1 request", 32'(irqReq), 32'h2);
    chk("R10 core1 pin2", 32'(irqPin), 32'h1 << (1*NP + 2));
    srcIn[3] = 1'b0; wait3();
    rdchk("R3 level release", 5'h08, 32'h0);
    wr(5'h01, {1'b0, 23'b001, 8'd3});
    rdchk("R3 active-low pending", 5'h08, 32'h08);

    // source 5: rising edge
    wr(5'h01, {1'b0, 23'b010, 8'd5});
    wr(5'h02, 32'd5);
    srcIn[5] = 1'b1; wait3();
    srcIn[5] = 1'b0; wait3();
    rdchk("R4 rising latch holds", 5'h08, 32'h28);
    wr(5'h04, {1'b0, 23'd0, 8'd5});
    rdchk("R6 ack clears latch", 5'h08, 32'h08);
    // falling
    wr(5'h01, {1'b0, 23'b011, 8'd5});
    srcIn[5] = 1'b1; wait3();
    rdchk("R4 falling ignores rise", 5'h08, 32'h08);
    srcIn[5] = 1'b0; wait3();
    rdchk("R4 falling latch", 5'h08, 32'h28);
    wr(5'h04, {1'b0, 23'd0, 8'd5});

    // source 6: dual edge with polarity bit set
    wr(5'h01, {1'b0, 23'b111, 8'd6});
    srcIn[6] = 1'b1; wait3();
    rdchk("R5 dual rise", 5'h08, 32'h48);
    wr(5'h04, {1'b0, 23'd0, 8'd6});
    srcIn[6] = 1'b0; wait3();
    rdchk("R5 dual fall", 5'h08, 32'h48);
    wr(5'h04, {1'b0, 23'd0, 8'd6});

    // hardware edge coincides with acknowledge
    wr(5'h01, {1'b0, 23'b010, 8'd5});
    srcIn[5] = 1'b1; tick(); tick();
    wr(5'h04, {1'b0, 23'd0, 8'd5});
    rdchk("R6 edge beats ack", 5'h08, 32'h28);
    wr(5'h04, {1'b0, 23'd0, 8'd5});
    srcIn[5] = 1'b0; wait3();

    // source 7: software-raised, pin 0, core 3
    wr(5'h01, {1'b0, 23'b010, 8'd7});
    wr(5'h05, {1'b1, 23'd0, 8'd7});
    wr(5'h06, {1'b0, 23'b1000, 8'd7});
    wr(5'h02, 32'd7);
    wr(5'h04, {1'b1, 23'd0, 8'd7});
    rdchk("R7 software set", 5'h08, 32'h88);
    chk("R9 two cores", 32'(irqReq), 32'ha);
    chk("R10 core3 pin0", 32'(irqPin), (32'h1 << (3*NP)) | (32'h1 << (1*NP + 2)));

    wr(5'h03, 32'd3);
    chk("R8 disable drops request", 32'(irqReq), 32'h8);
    rdchk("R8 enable word", 5'h10, 32'ha0);
    rdchk("R8 pending kept", 5'h08, 32'h88);

    wr(5'h02, 32'd16);
    wr(5'h02, 32'd200);
    rdchk("R12 index out of range", 5'h10, 32'ha0);
    wr(5'h06, {1'b0, 23'h20, 8'd7});
    chk("R12 core bit out of range", 32'(irqReq), 32'h8);
    wr(5'h04, {1'b1, 23'd0, 8'd20});
    rdchk("R12 edge index out of range", 5'h08, 32'h88);

    wr(5'h05, {1'b1, 23'd7, 8'd7});
    chk("R10 pin out of range keeps request", 32'(irqReq), 32'h8);
    chk("R10 pin out of range no pin", 32'(irqPin), 32'h0);
    wr(5'h05, {1'b0, 23'd0, 8'd7});
    chk("R9 pin flag off", 32'(irqReq), 32'h0);

    rdchk("R11 word1 pending", 5'h09, 32'h0);
    rdchk("R11 word1 enables", 5'h11, 32'h0);
    rdchk("R11 unused address", 5'h1f, 32'h0);

    // top source index
    wr(5'h02, 32'd15);
    wr(5'h05, {1'b1, 23'd5, 8'd15});
    wr(5'h06, {1'b0, 23'b0001, 8'd15});
    srcIn[15] = 1'b1; wait3();
    rdchk("R1 top source pending", 5'h08, 32'h8088);
    chk("R1 top source request", 32'(irqReq), 32'h1);
    chk("R10 core0 pin5", 32'(irqPin), 32'h20);

    tick();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog act=running exp=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule